// File: doc/BRIEF.md
# Multiply-Accumulate Peripheral

This block is a 32x32 unsigned multiplier with a 64-bit accumulator. It sits beside a processor core and is reached through register transfers. The core always presents two operand registers to it. It reads results back through a transfer port. That port is addressed by a start register number, a byte lane and a byte length. The peripheral decodes three 32-bit registers at transfer numbers 25, 26 and 27:

- Register 25 is the control word.
- Register 26 holds the low half of the product.
- Register 27 holds the high half of the product.

The block has two timing regimes, chosen by the mode bit. In multiply-only mode it multiplies the operands on every clock and keeps the accumulator at zero. In accumulate mode it advances only on a valid write transfer. Each such write adds the current product into the 64-bit accumulator and copies the new sum into the product registers. An overflow of that addition sets a sticky carry flag. Writing a 1 to the carry bit clears the flag and zeroes the accumulator.

A transfer must start at register 25 or above and must end no later than byte 112 (4 x 28). Any other transfer is rejected with a one-cycle error pulse and changes nothing.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous reset, product, accumulator, mode bit, carry flag, error pulse and read-valid are all zero.
- R2: While the mode bit is 0, the product output one clock later equals the 64-bit unsigned product of the two operand inputs present at that edge. This holds on every clock.
- R3: While the mode bit is 0, the accumulator is zero on the following clock.
- R4: The control byte is byte 0 of register 25. Bit 0 is the mode (0 = multiply-only, 1 = accumulate) and bit 1 is the carry flag. A valid write whose byte range covers that byte loads the mode from bit 0 of `xfr_ctl_i`.
- R5: In accumulate mode, each valid write transfer that is not a carry clear adds the operand product to the accumulator. The product and accumulator outputs both show the truncated 64-bit sum one clock later. Without a write, both hold, whatever the operands do.
- R6: A carry out of the 64-bit accumulate sets the carry flag. The flag stays set through later accumulates.
- R7: A valid write covering the control byte with bit 1 of `xfr_ctl_i` set clears the carry flag. In accumulate mode it also zeroes the accumulator, performs no accumulate in that cycle and leaves the product unchanged.
- R8: A transfer is valid only if start register >= 25 and start*4 + lane + length <= 112. An invalid read or write pulses `err_o` for one clock and changes no state. A valid one leaves `err_o` low.
- R9: A valid read raises `rd_valid_o` one clock later with a 96-bit image. Image bytes 0-3 are the control word, 4-7 the product low word and 8-11 the product high word. Only bytes from offset (start-25)*4+lane up to length bytes are kept, and the others read as zero. The image reflects state before any update made in the same cycle.
- R10: A write uses the mode held before that write. A write that switches the mode performs the step of the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a_i | input | 32 | First operand (core register 28) |
| op_b_i | input | 32 | Second operand (core register 29) |
| xfr_wr_i | input | 1 | Write transfer strobe |
| xfr_rd_i | input | 1 | Read transfer strobe |
| xfr_reg_i | input | 5 | Start register number |
| xfr_lane_i | input | 2 | Start byte lane within the register |
| xfr_len_i | input | 7 | Transfer length in bytes |
| xfr_ctl_i | input | 2 | Writable control bits: bit 0 mode, bit 1 carry clear |
| prod_o | output | 64 | Product register (high word above low word) |
| acc_o | output | 64 | Accumulator |
| mode_o | output | 1 | Current mode bit |
| carry_o | output | 1 | Sticky accumulate carry flag |
| rd_data_o | output | 96 | Byte-masked readback image |
| rd_valid_o | output | 1 | Read data valid pulse |
| err_o | output | 1 | Invalid transfer pulse |

## Verification
Every result in this block is a single register stage away from its cause. The multiply-only product, the accumulate sum, the carry flag, the mode change, the read image and the error pulse all appear at the first rising edge after the stimulus is driven. The bench drives each stimulus at a falling edge and samples one time unit after the next rising edge, so every check sees exactly one update. In multiply-only mode the product is overwritten on every clock, so the operands are held steady across reads of it. The switch out of accumulate mode takes two edges: the switching write still accumulates, and the next edge zeroes the accumulator. The bench checks the accumulator at both edges.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Control byte bit positions inside register 25.
  localparam int CTL_MODE_BIT  = 0;
  localparam int CTL_CARRY_BIT = 1;

  typedef struct packed {
    logic carry;
    logic acc_en;
  } mac_ctl_t;
endpackage

// File: rtl/mac_xfr_decode.sv
module mac_xfr_decode #(
  parameter int REGW      = 5,
  parameter int LANEW     = 2,
  parameter int LENW      = 7,
  parameter int FIRST_REG = 25,
  parameter int NREGS     = 3,
  parameter int BPR       = 4
) (
  input  logic [REGW-1:0]        reg_i,
  input  logic [LANEW-1:0]       lane_i,
  input  logic [LENW-1:0]        len_i,
  output logic                   valid_o,
  output logic [NREGS*BPR-1:0]   mask_o
);
  localparam int NBYTES = NREGS * BPR;
  localparam int SUMW   = REGW + LENW + 4;
  localparam int BASE   = FIRST_REG * BPR;
  localparam int LIMIT  = (FIRST_REG + NREGS) * BPR;

  logic [SUMW-1:0] abs_start;
  logic [SUMW-1:0] abs_end;

  always_comb begin
    abs_start = SUMW'(reg_i) * SUMW'(BPR) + SUMW'(lane_i);
    abs_end   = abs_start + SUMW'(len_i);
    valid_o   = (reg_i >= REGW'(FIRST_REG)) && (abs_end <= SUMW'(LIMIT));
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_mask
    localparam logic [SUMW-1:0] ABS = SUMW'(BASE + i);
    assign mask_o[i] = (ABS >= abs_start) && (ABS < abs_end);
  end
endmodule

// File: rtl/mac_core.sv
module mac_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           step_i,
  input  logic           mode_wr_i,
  input  logic           mode_val_i,
  input  logic           clr_i,
  output logic [2*W-1:0] prod_o,
  output logic [2*W-1:0] acc_o,
  output logic           mode_o,
  output logic           carry_o
);
  import mac_pkg::*;

  localparam int DW = 2 * W;

  logic [DW-1:0] prod_q, acc_q, mul;
  logic [DW:0]   sum_ext;
  mac_ctl_t      ctl_q;

  always_comb begin
    mul     = DW'(a_i) * DW'(b_i);
    sum_ext = {1'b0, acc_q} + {1'b0, mul};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      acc_q  <= '0;
      ctl_q  <= '0;
    end else begin
      if (mode_wr_i) ctl_q.acc_en <= mode_val_i;
      if (!ctl_q.acc_en) begin
        prod_q <= mul;
        acc_q  <= '0;
        if (clr_i) ctl_q.carry <= 1'b0;
      end else if (clr_i) begin
        acc_q       <= '0;
        ctl_q.carry <= 1'b0;
      end else if (step_i) begin
        prod_q <= sum_ext[DW-1:0];
        acc_q  <= sum_ext[DW-1:0];
        if (sum_ext[DW]) ctl_q.carry <= 1'b1;
      end
    end
  end

  assign prod_o  = prod_q;
  assign acc_o   = acc_q;
  assign mode_o  = ctl_q.acc_en;
  assign carry_o = ctl_q.carry;

  a_r2_mul_every_clock: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.acc_en |=> prod_q == (DW'($past(a_i)) * DW'($past(b_i))));

  a_r3_acc_held_zero: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.acc_en |=> acc_q == '0);

  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.acc_en && !step_i && !clr_i) |=> ($stable(acc_q) && $stable(prod_q)));

  a_r6_carry_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.carry && !clr_i) |=> ctl_q.carry);

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.acc_en && clr_i) |=> (acc_q == '0 && !ctl_q.carry && $stable(prod_q)));
endmodule

// File: rtl/mac_readback.sv
module mac_readback #(
  parameter int NBYTES = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_i,
  input  logic                bad_i,
  input  logic [NBYTES-1:0]   mask_i,
  input  logic [NBYTES*8-1:0] image_i,
  output logic [NBYTES*8-1:0] rd_data_o,
  output logic                rd_valid_o,
  output logic                err_o
);
  logic [NBYTES*8-1:0] bitmask;

  for (genvar i = 0; i < NBYTES; i++) begin : g_expand
    assign bitmask[i*8 +: 8] = {8{mask_i[i]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      err_o      <= bad_i;
      if (rd_i) rd_data_o <= image_i & bitmask;
    end
  end

  a_r9_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_i));
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int W         = 32,
  parameter int REGW      = 5,
  parameter int LANEW     = 2,
  parameter int LENW      = 7,
  parameter int FIRST_REG = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        op_a_i,
  input  logic [W-1:0]        op_b_i,
  input  logic                xfr_wr_i,
  input  logic                xfr_rd_i,
  input  logic [REGW-1:0]     xfr_reg_i,
  input  logic [LANEW-1:0]    xfr_lane_i,
  input  logic [LENW-1:0]     xfr_len_i,
  input  logic [1:0]          xfr_ctl_i,
  output logic [2*W-1:0]      prod_o,
  output logic [2*W-1:0]      acc_o,
  output logic                mode_o,
  output logic                carry_o,
  output logic [3*W-1:0]      rd_data_o,
  output logic                rd_valid_o,
  output logic                err_o
);
  import mac_pkg::*;

  localparam int NREGS  = 3;
  localparam int BPR    = W / 8;
  localparam int NBYTES = NREGS * BPR;

  logic              xfr_ok, wr_ok, rd_ok, bad, ctl_hit;
  logic [NBYTES-1:0] mask;
  logic [3*W-1:0]    image;

  mac_xfr_decode #(
    .REGW(REGW), .LANEW(LANEW), .LENW(LENW),
    .FIRST_REG(FIRST_REG), .NREGS(NREGS), .BPR(BPR)
  ) i_decode (
    .reg_i  (xfr_reg_i),
    .lane_i (xfr_lane_i),
    .len_i  (xfr_len_i),
    .valid_o(xfr_ok),
    .mask_o (mask)
  );

  always_comb begin
    wr_ok   = xfr_wr_i && xfr_ok;
    rd_ok   = xfr_rd_i && xfr_ok;
    bad     = (xfr_wr_i || xfr_rd_i) && !xfr_ok;
    ctl_hit = wr_ok && mask[0];
    image   = {prod_o, (W-2)'(0), carry_o, mode_o};
  end

  mac_core #(.W(W)) i_core (
    .clk       (clk),
    .rst       (rst),
    .a_i       (op_a_i),
    .b_i       (op_b_i),
    .step_i    (wr_ok),
    .mode_wr_i (ctl_hit),
    .mode_val_i(xfr_ctl_i[CTL_MODE_BIT]),
    .clr_i     (ctl_hit && xfr_ctl_i[CTL_CARRY_BIT]),
    .prod_o    (prod_o),
    .acc_o     (acc_o),
    .mode_o    (mode_o),
    .carry_o   (carry_o)
  );

  mac_readback #(.NBYTES(NBYTES)) i_readback (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (rd_ok),
    .bad_i     (bad),
    .mask_i    (mask),
    .image_i   (image),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o),
    .err_o     (err_o)
  );

  a_r8_low_register_rejected: assert property (@(posedge clk) disable iff (rst)
    ((xfr_wr_i || xfr_rd_i) && xfr_reg_i < REGW'(FIRST_REG)) |=> err_o);

  a_r8_invalid_write_no_change: assert property (@(posedge clk) disable iff (rst)
    (xfr_wr_i && !xfr_rd_i && xfr_reg_i < REGW'(FIRST_REG) && mode_o)
      |=> ($stable(acc_o) && $stable(mode_o) && $stable(carry_o)));
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  rnum = '0;
  logic [1:0]  lane = '0;
  logic [6:0]  len = '0;
  logic [1:0]  ctl = '0;
  logic [63:0] prod, acc;
  logic        mode, carry, rd_valid, err;
  logic [95:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst(rst), .op_a_i(op_a), .op_b_i(op_b),
    .xfr_wr_i(wr), .xfr_rd_i(rd), .xfr_reg_i(rnum), .xfr_lane_i(lane),
    .xfr_len_i(len), .xfr_ctl_i(ctl), .prod_o(prod), .acc_o(acc),
    .mode_o(mode), .carry_o(carry), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .err_o(err)
  );

  task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Drive one cycle at a falling edge, sample just after the next rising edge.
  task automatic cycle(input logic [31:0] a, input logic [31:0] b, input bit w, input bit r,
                       input logic [4:0] rn, input logic [1:0] ln, input logic [6:0] lg,
                       input logic [1:0] c);
    @(negedge clk);
    op_a = a; op_b = b; wr = w; rd = r; rnum = rn; lane = ln; len = lg; ctl = c;
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 prod", 96'(prod), 96'h0);
    check("R1 acc", 96'(acc), 96'h0);
    check("R1 mode/carry/err/rdv", {92'h0, mode, carry, err, rd_valid}, 96'h0);
  endtask

  task automatic t_multiply_only();
    cycle(32'd3, 32'd5, 0, 0, 0, 0, 0, 0);
    check("R2 3*5", 96'(prod), 96'd15);
    cycle(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    check("R2 max*max", 96'(prod), 96'h0_FFFFFFFE_00000001);
    check("R3 acc zero", 96'(acc), 96'h0);
    cycle(32'h1234_5678, 32'h10, 0, 0, 0, 0, 0, 0);
    check("R2 shifted", 96'(prod), 96'h1_23456780);
  endtask

  task automatic t_readback();
    cycle(32'h1234_5678, 32'h10, 0, 1, 5'd26, 2'd0, 7'd8, 0);
    check("R9 rd_valid", 96'(rd_valid), 96'h1);
    check("R9 product words", rd_data, {64'h1_23456780, 32'h0});
    cycle(32'h1234_5678, 32'h10, 0, 1, 5'd26, 2'd1, 7'd2, 0);
    check("R9 two-byte window", rd_data, 96'h4567 << 40);
    cycle(32'h1234_5678, 32'h10, 0, 0, 0, 0, 0, 0);
    check("R9 valid is a pulse", 96'(rd_valid), 96'h0);
  endtask

  task automatic t_accumulate();
    cycle(32'd3, 32'd5, 1, 0, 5'd25, 2'd0, 7'd1, 2'b01);
    check("R4 mode set", 96'(mode), 96'h1);
    check("R10 switching write multiplies", 96'(prod), 96'd15);
    check("R10 switching write acc", 96'(acc), 96'h0);
    cycle(32'd7, 32'd9, 0, 0, 0, 0, 0, 0);
    cycle(32'd8, 32'd9, 0, 0, 0, 0, 0, 0);
    check("R5 hold prod", 96'(prod), 96'd15);
    check("R5 hold acc", 96'(acc), 96'h0);
    cycle(32'd3, 32'd5, 1, 0, 5'd27, 2'd0, 7'd4, 0);
    check("R5 first step", 96'(acc), 96'd15);
    cycle(32'd7, 32'd11, 1, 0, 5'd26, 2'd0, 7'd4, 0);
    check("R5 second step acc", 96'(acc), 96'd92);
    check("R5 second step prod", 96'(prod), 96'd92);
  endtask

  task automatic t_overflow_and_clear();
    cycle(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 5'd26, 2'd0, 7'd4, 0);
    check("R5 large step", 96'(acc), 96'hFFFFFFFE_0000005D);
    check("R6 no carry yet", 96'(carry), 96'h0);
    cycle(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 5'd26, 2'd0, 7'd4, 0);
    check("R6 wrap value", 96'(acc), 96'hFFFFFFFC_0000005E);
    check("R6 carry set", 96'(carry), 96'h1);
    cycle(32'd1, 32'd1, 1, 0, 5'd26, 2'd0, 7'd4, 0);
    check("R6 carry sticky", 96'(carry), 96'h1);
    check("R6 acc after sticky step", 96'(acc), 96'hFFFFFFFC_0000005F);
    cycle(32'd1, 32'd1, 0, 1, 5'd25, 2'd0, 7'd1, 0);
    check("R9 control byte", rd_data, 96'h3);
    cycle(32'd2, 32'd2, 1, 0, 5'd25, 2'd0, 7'd1, 2'b11);
    check("R7 acc cleared", 96'(acc), 96'h0);
    check("R7 carry cleared, mode kept", {94'h0, mode, carry}, 96'h2);
    check("R7 prod kept", 96'(prod), 96'hFFFFFFFC_0000005F);
  endtask

  task automatic t_validity();
    cycle(32'd2, 32'd3, 1, 0, 5'd24, 2'd3, 7'd2, 2'b00);
    check("R8 low reg err", 96'(err), 96'h1);
    check("R8 low reg no step", 96'(acc), 96'h0);
    check("R8 low reg mode untouched", 96'(mode), 96'h1);
    cycle(32'd2, 32'd3, 1, 0, 5'd27, 2'd3, 7'd2, 0);
    check("R8 past end err", 96'(err), 96'h1);
    check("R8 past end no step", 96'(acc), 96'h0);
    cycle(32'd2, 32'd3, 1, 0, 5'd27, 2'd3, 7'd1, 0);
    check("R8 last byte ok", 96'(err), 96'h0);
    check("R8 last byte steps", 96'(acc), 96'd6);
    cycle(32'd2, 32'd3, 0, 1, 5'd28, 2'd0, 7'd1, 0);
    check("R8 bad read err/valid", {94'h0, err, rd_valid}, 96'h2);
  endtask

  task automatic t_back_to_multiply();
    cycle(32'd4, 32'd5, 1, 0, 5'd25, 2'd0, 7'd1, 2'b00);
    check("R10 leaving write accumulates", 96'(acc), 96'd26);
    check("R4 mode cleared", 96'(mode), 96'h0);
    cycle(32'd4, 32'd5, 0, 0, 0, 0, 0, 0);
    check("R3 acc zero after leaving", 96'(acc), 96'h0);
    check("R2 multiply resumes", 96'(prod), 96'd20);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_multiply_only();
    t_readback();
    t_accumulate();
    t_overflow_and_clear();
    t_validity();
    t_back_to_multiply();
    finish_run();
  end
endmodule